// File: doc/BRIEF.md
# Paged Digital I/O Register Bank

This block is a byte-wide register bank for a host. It controls forty-eight open-drain lines arranged as six 8-bit ports. The host uses a simple synchronous interface: a write strobe, a 4-bit offset, write data and a combinational read-data bus. A 1 in a port data bit pulls the matching line low. A 0 releases the line, and an external pull-up then holds it high. Reading a port returns the synchronized line level inverted.

Offset 07h is shared by two functions. Its two top bits select one of four pages. Its six low bits are per-port write locks. The page decides what offsets 08h to 0Ah reach: an interrupt configuration byte and two revision bytes, the per-bit edge polarity for ports 0 to 2, the per-bit edge enable for those ports, or the latched interrupt flags for those ports. Offset 06h summarizes which of the first three ports has a latched flag. The single interrupt output is the OR of every flag, gated by a master enable bit.

Top module: `pagedIoBank`

## Requirements
- R1: Writing offset n (0 to 5) stores the byte as the drive register of port n. Bit b of that byte appears on pinDriveLow[8n+b] on the clock edge that samples the write, where 1 pulls the line low and 0 releases it.
- R2: Reading offset n (0 to 5) returns the inverse of pinIn[8n+7:8n] as seen through a two-flop synchronizer. A pin change becomes visible after the second rising clock edge.
- R3: Bits 5:0 of offset 07h are write locks for ports 5 to 0. While the lock bit of port n is 1, writes to offset n leave that port's drive unchanged.
- R4: Bits 7:6 of offset 07h hold the page number (0 to 3). Offset 07h reads back the last byte written to it.
- R5: On page 0, offset 08h is a read/write configuration byte whose bit 0 is the interrupt master enable. Offsets 09h and 0Ah read the fixed revision constants REV_LO and REV_HI, and writes to them are ignored.
- R6: On page 1, offsets 08h, 09h and 0Ah are the read/write polarity bytes of ports 0, 1 and 2. On page 2, the same offsets are the read/write enable bytes of those ports.
- R7: A flag bit is set when its enable bit is 1 and the synchronized pin shows an edge of the selected polarity (1 = rising, 0 = falling). The flag is set on the third rising clock edge after the pin changes. Edges of the other direction, and edges on disabled bits, never set a flag.
- R8: On page 3, offsets 08h, 09h and 0Ah read the flag bytes of ports 0, 1 and 2. Writing 0 to a flag bit clears it and writing 1 keeps it. A qualifying edge in the same cycle as the clear leaves the flag set.
- R9: Offset 06h reads bit k (k = 0..2) as 1 when port k has any flag set, and reads bits 7:3 as 0. Writes to 06h have no effect.
- R10: irqOut is 1 exactly when the master enable is 1 and at least one flag bit is set.
- R11: After reset all lines are released, irqOut is 0, and offsets 07h and 06h read 00h.
- R12: Offsets 0Bh to 0Fh read 00h, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current offset (combinational) |
| pinIn | input | 48 | Line levels as seen at the pads |
| pinDriveLow | output | 48 | 1 = pull the line low, 0 = release it |
| irqOut | output | 1 | Interrupt request |

## Verification
A corrupted drive bit appears on pinDriveLow on the very next edge. A wrong lock or page value shows up at once in the readback of 07h, and a wrong page also sends later paged writes to the wrong register. A bad synchronizer or edge detector shows as a flag that is missing, set early or set by the wrong edge direction. This is visible through irqOut and the 06h summary exactly three edges after the pin change. The collision between a clear and a new edge is driven on purpose, so a flag lost in that cycle is caught.

// File: rtl/pioPkg.sv
package pioPkg;
  localparam int NUM_PORTS     = 6;
  localparam int PORT_W        = 8;
  localparam int NUM_IRQ_PORTS = 3;
  localparam int ADDR_W        = 4;
  localparam int PAGE_W        = 2;
  localparam int PIN_W         = NUM_PORTS * PORT_W;
  localparam int IRQ_PIN_W     = NUM_IRQ_PORTS * PORT_W;
  localparam int IDX_W         = $clog2(NUM_PORTS);
  localparam int PEND_OFS      = NUM_PORTS;
  localparam int PGLK_OFS      = NUM_PORTS + 1;
  localparam int PAGED_OFS     = NUM_PORTS + 2;

  typedef struct packed {
    logic [NUM_PORTS-1:0]     portWr;
    logic                     cfgWr;
    logic [NUM_IRQ_PORTS-1:0] polWr;
    logic [NUM_IRQ_PORTS-1:0] enWr;
    logic [NUM_IRQ_PORTS-1:0] idWr;
  } ctlStrobe_t;

  typedef enum logic [3:0] {
    RS_NONE, RS_PORT, RS_PEND, RS_PGLK, RS_CFG,
    RS_REVLO, RS_REVHI, RS_POL, RS_EN, RS_ID
  } readSel_e;
endpackage

// File: rtl/pioControl.sv
module pioControl
  import pioPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PORT_W-1:0]    wrData,
  output ctlStrobe_t           strobe,
  output readSel_e             readSel,
  output logic [IDX_W-1:0]     readIdx,
  output logic [PORT_W-1:0]    pageLock
);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_PGLK  = ADDR_W'(PGLK_OFS);
  localparam logic [ADDR_W-1:0] A_PAGED = ADDR_W'(PAGED_OFS);
  localparam logic [ADDR_W-1:0] A_PORTS = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(PAGED_OFS + NUM_IRQ_PORTS);

  logic [PAGE_W-1:0]    pageQ;
  logic [NUM_PORTS-1:0] lockQ;
  logic [1:0]           pagedIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      lockQ <= '0;
    end else if (wrEn && addr == A_PGLK) begin
      pageQ <= wrData[PORT_W-1 -: PAGE_W];
      lockQ <= wrData[NUM_PORTS-1:0];
    end
  end

  assign pageLock = {pageQ, lockQ};
  assign pagedIdx = 2'(addr - A_PAGED);

  always_comb begin
    strobe  = '0;
    readSel = RS_NONE;
    readIdx = '0;
    if (addr < A_PORTS) begin
      readSel = RS_PORT;
      readIdx = IDX_W'(addr);
      if (wrEn && !lockQ[IDX_W'(addr)]) strobe.portWr[IDX_W'(addr)] = 1'b1;
    end else if (addr == A_PEND) begin
      readSel = RS_PEND;
    end else if (addr == A_PGLK) begin
      readSel = RS_PGLK;
    end else if (addr < A_END) begin
      readIdx = IDX_W'(pagedIdx);
      case (pageQ)
        2'd0: begin
          case (pagedIdx)
            2'd0:    readSel = RS_CFG;
            2'd1:    readSel = RS_REVLO;
            default: readSel = RS_REVHI;
          endcase
          strobe.cfgWr = wrEn && pagedIdx == 2'd0;
        end
        2'd1: begin
          readSel = RS_POL;
          strobe.polWr[pagedIdx] = wrEn;
        end
        2'd2: begin
          readSel = RS_EN;
          strobe.enWr[pagedIdx] = wrEn;
        end
        default: begin
          readSel = RS_ID;
          strobe.idWr[pagedIdx] = wrEn;
        end
      endcase
    end
  end

  // R4: a write to the page/lock register sets the page on the next edge
  p_page_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_PGLK) |=> (pageQ == $past(wrData[PORT_W-1 -: PAGE_W])));
endmodule

// File: rtl/pioDatapath.sv
module pioDatapath
  import pioPkg::*;
#(
  parameter logic [PORT_W-1:0] REV_LO = 8'h1A,
  parameter logic [PORT_W-1:0] REV_HI = 8'h02
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  readSel_e             readSel,
  input  logic [IDX_W-1:0]     readIdx,
  input  logic [PORT_W-1:0]    pageLock,
  input  logic [PORT_W-1:0]    wrData,
  input  logic [PIN_W-1:0]     pinIn,
  output logic [PIN_W-1:0]     pinDriveLow,
  output logic [PORT_W-1:0]    rdData,
  output logic                 irqOut
);
  logic [PIN_W-1:0]         driveQ;
  logic [PIN_W-1:0]         meta1Q;
  logic [PIN_W-1:0]         syncQ;
  logic [IRQ_PIN_W-1:0]     prevQ;
  logic [PORT_W-1:0]        cfgQ;
  logic [PORT_W-1:0]        polQ  [NUM_IRQ_PORTS];
  logic [PORT_W-1:0]        enQ   [NUM_IRQ_PORTS];
  logic [PORT_W-1:0]        idQ   [NUM_IRQ_PORTS];
  logic [PORT_W-1:0]        hit   [NUM_IRQ_PORTS];
  logic [NUM_IRQ_PORTS-1:0] anyPend;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) driveQ[gp*PORT_W +: PORT_W] <= '0;
        else if (strobe.portWr[gp]) driveQ[gp*PORT_W +: PORT_W] <= wrData;
      end
    end
  endgenerate

  assign pinDriveLow = driveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta1Q <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
      cfgQ   <= '0;
    end else begin
      meta1Q <= pinIn;
      syncQ  <= meta1Q;
      prevQ  <= syncQ[IRQ_PIN_W-1:0];
      if (strobe.cfgWr) cfgQ <= wrData;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ_PORTS; gi++) begin : g_irq
      logic [PORT_W-1:0] curLvl, oldLvl;
      assign curLvl = syncQ[gi*PORT_W +: PORT_W];
      assign oldLvl = prevQ[gi*PORT_W +: PORT_W];
      assign hit[gi] = enQ[gi] & ((polQ[gi] & curLvl & ~oldLvl) |
                                  (~polQ[gi] & ~curLvl & oldLvl));
      assign anyPend[gi] = |idQ[gi];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          polQ[gi] <= '0;
          enQ[gi]  <= '0;
          idQ[gi]  <= '0;
        end else begin
          if (strobe.polWr[gi]) polQ[gi] <= wrData;
          if (strobe.enWr[gi])  enQ[gi]  <= wrData;
          idQ[gi] <= (strobe.idWr[gi] ? (idQ[gi] & wrData) : idQ[gi]) | hit[gi];
        end
      end

      // R7: a flag bit may only rise where the enable bit was set
      p_flag_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
        ((idQ[gi] & ~$past(idQ[gi]) & ~$past(enQ[gi])) == '0));

      // R8: a qualifying edge survives a same-cycle clear
      p_edge_beats_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
        (hit[gi] != '0) |=> ((idQ[gi] & $past(hit[gi])) == $past(hit[gi])));
    end
  endgenerate

  assign irqOut = cfgQ[0] & (|anyPend);

  always_comb begin
    rdData = '0;
    case (readSel)
      RS_PORT:  rdData = ~syncQ[{readIdx, 3'b000} +: PORT_W];
      RS_PEND:  rdData = PORT_W'(anyPend);
      RS_PGLK:  rdData = pageLock;
      RS_CFG:   rdData = cfgQ;
      RS_REVLO: rdData = REV_LO;
      RS_REVHI: rdData = REV_HI;
      RS_POL:   rdData = polQ[readIdx[1:0]];
      RS_EN:    rdData = enQ[readIdx[1:0]];
      RS_ID:    rdData = idQ[readIdx[1:0]];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pagedIoBank.sv
module pagedIoBank
  import pioPkg::*;
#(
  parameter logic [7:0] REV_LO = 8'h1A,
  parameter logic [7:0] REV_HI = 8'h02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [47:0] pinIn,
  output logic [47:0] pinDriveLow,
  output logic        irqOut
);
  ctlStrobe_t       strobe;
  readSel_e         readSel;
  logic [IDX_W-1:0] readIdx;
  logic [7:0]       pageLock;

  pioControl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .readSel(readSel), .readIdx(readIdx), .pageLock(pageLock)
  );

  pioDatapath #(.REV_LO(REV_LO), .REV_HI(REV_HI)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readSel(readSel),
    .readIdx(readIdx), .pageLock(pageLock), .wrData(wrData), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .rdData(rdData), .irqOut(irqOut)
  );

  // R3: a write to a locked port leaves the line drive unchanged
  p_locked_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr < 4'd6 && pageLock[addr[2:0]]) |=> $stable(pinDriveLow));

  // R9: the pending summary never reports above port 2
  p_pend_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 4'd6) |-> (rdData[7:3] == 5'd0));
endmodule

// File: tb/pagedIoBank_tb.sv
module pagedIoBank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] extLvl = '1;
  logic [47:0] pinIn;
  logic [47:0] pinDriveLow;
  logic        irqOut;
  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;

  logic [47:0] driveM;
  logic [5:0]  lockM;
  logic [7:0]  pglkM;

  assign pinIn = extLvl & ~pinDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagedIoBank #(.REV_LO(8'h1A), .REV_HI(8'h02)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinDriveLow(pinDriveLow), .irqOut(irqOut)
  );

  function automatic logic [7:0] portView(logic [47:0] ext, logic [47:0] drv, int p);
    return ~(ext[p*8 +: 8] & ~drv[p*8 +: 8]);
  endfunction

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    // R11 reset state
    chk("R11 drive", pinDriveLow, 48'h0);
    chk("R11 irq", {47'h0, irqOut}, 48'h0);
    rd(4'h7, v); chk("R11 pglk", {40'h0, v}, 48'h0);
    rd(4'h6, v); chk("R11 pend", {40'h0, v}, 48'h0);

    // R1 drive, R2 inverted read
    wr(4'h2, 8'hA5);
    chk("R1 drive", pinDriveLow, 48'h0000_00A5_0000);
    cyc(2);
    rd(4'h2, v); chk("R2 driven port", {40'h0, v}, 48'hA5);
    extLvl[47:40] = 8'h0F;
    cyc(1);
    rd(4'h5, v); chk("R2 one edge stale", {40'h0, v}, 48'h00);
    cyc(1);
    rd(4'h5, v); chk("R2 after sync", {40'h0, v}, 48'hF0);
    extLvl = '1;
    wr(4'h2, 8'h00);

    // R3 lock
    wr(4'h7, 8'h04);
    wr(4'h2, 8'hFF);
    chk("R3 locked write", pinDriveLow, 48'h0);
    wr(4'h7, 8'h00);
    wr(4'h2, 8'h3C);
    chk("R3 unlocked write", pinDriveLow, 48'h0000_003C_0000);
    wr(4'h2, 8'h00);

    // R4 page readback
    wr(4'h7, 8'hC5);
    rd(4'h7, v); chk("R4 pglk readback", {40'h0, v}, 48'hC5);
    wr(4'h7, 8'h00);

    // R5 page 0
    wr(4'h9, 8'h77);
    rd(4'h9, v); chk("R5 rev lo", {40'h0, v}, 48'h1A);
    rd(4'hA, v); chk("R5 rev hi", {40'h0, v}, 48'h02);
    wr(4'h8, 8'h81);
    rd(4'h8, v); chk("R5 cfg", {40'h0, v}, 48'h81);

    // R6 polarity and enable
    wr(4'h7, 8'h40); wr(4'h8, 8'h01); wr(4'h9, 8'h00); wr(4'hA, 8'h5A);
    rd(4'hA, v); chk("R6 pol2", {40'h0, v}, 48'h5A);
    wr(4'hA, 8'h00);
    wr(4'h7, 8'h80); wr(4'h8, 8'h01); wr(4'h9, 8'h80);
    rd(4'h9, v); chk("R6 en1", {40'h0, v}, 48'h80);
    rd(4'h8, v); chk("R6 en0", {40'h0, v}, 48'h01);

    // R7 rising on port0 bit0, falling on port1 bit7
    wr(4'h7, 8'hC0);
    extLvl[0] = 1'b0;
    cyc(3);
    rd(4'h8, v); chk("R7 wrong direction", {40'h0, v}, 48'h00);
    extLvl[1] = 1'b0;
    cyc(3);
    rd(4'h8, v); chk("R7 disabled bit", {40'h0, v}, 48'h00);
    extLvl[1] = 1'b1;
    extLvl[0] = 1'b1;
    cyc(2);
    chk("R7 not before third edge", {47'h0, irqOut}, 48'h0);
    cyc(1);
    chk("R10 irq on flag", {47'h0, irqOut}, 48'h1);
    rd(4'h8, v); chk("R7 rising flag", {40'h0, v}, 48'h01);
    rd(4'h6, v); chk("R9 pend port0", {40'h0, v}, 48'h01);
    extLvl[15] = 1'b0;
    cyc(3);
    rd(4'h9, v); chk("R7 falling flag", {40'h0, v}, 48'h80);
    rd(4'h6, v); chk("R9 pend ports 0,1", {40'h0, v}, 48'h03);
    wr(4'h6, 8'h00);
    rd(4'h6, v); chk("R9 write ignored", {40'h0, v}, 48'h03);

    // R8 clear semantics
    wr(4'h9, 8'h7F);
    rd(4'h9, v); chk("R8 clear by 0", {40'h0, v}, 48'h00);
    wr(4'h8, 8'hFF);
    rd(4'h8, v); chk("R8 keep by 1", {40'h0, v}, 48'h01);

    // R10 master enable gate
    wr(4'h7, 8'h00); wr(4'h8, 8'h00);
    chk("R10 gated off", {47'h0, irqOut}, 48'h0);
    wr(4'h8, 8'h01);
    chk("R10 gated on", {47'h0, irqOut}, 48'h1);

    // R8 collision: clear lands with a new rising edge
    wr(4'h7, 8'hC0);
    extLvl[0] = 1'b0;
    cyc(3);
    extLvl[0] = 1'b1;
    cyc(2);
    wr(4'h8, 8'h00);
    rd(4'h8, v); chk("R8 edge beats clear", {40'h0, v}, 48'h01);
    wr(4'h8, 8'h00);
    rd(4'h8, v); chk("R8 clear no edge", {40'h0, v}, 48'h00);
    chk("R10 idle", {47'h0, irqOut}, 48'h0);

    // R12 unused offsets
    wr(4'hC, 8'hFF);
    rd(4'hC, v); chk("R12 read zero", {40'h0, v}, 48'h00);
    rd(4'h7, v); chk("R12 pglk kept", {40'h0, v}, 48'hC0);
    chk("R12 drive kept", pinDriveLow, 48'h0);

    // random port and lock traffic against a model (R1, R2, R3, R4)
    doReset();
    driveM = '0; lockM = '0; pglkM = '0;
    for (int it = 0; it < 150; it++) begin
      int op;
      int p;
      logic [7:0] d;
      extLvl = {$urandom(), $urandom()};
      op = $urandom % 4;
      if (op < 3) begin
        p = $urandom % 6;
        d = 8'($urandom);
        wr(4'(p), d);
        if (!lockM[p]) driveM[p*8 +: 8] = d;
      end else begin
        d = {2'($urandom), 6'($urandom & $urandom & $urandom)};
        wr(4'h7, d);
        pglkM = d; lockM = d[5:0];
      end
      cyc(2);
      chk("R1/R3 random drive", pinDriveLow, driveM);
      p = $urandom % 6;
      rd(4'(p), v); chk("R2 random read", {40'h0, v}, {40'h0, portView(extLvl, driveM, p)});
      rd(4'h7, v); chk("R4 random pglk", {40'h0, v}, {40'h0, pglkM});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule